// File: doc/BRIEF.md
# Sprite Attribute Write Port

This block is the processor-facing write side of a 544-byte sprite attribute store. The store is split into a 512-byte primary table, organised as 256 sixteen-bit words, and a 32-byte extension table. The processor first loads a 9-bit word pointer. It then streams bytes through a single write strobe. Bit 8 of the pointer decides which table is reached. Primary-table bytes arrive in pairs, and the pair is committed as one word. Extension bytes are stored the moment they arrive. A byte-phase bit and the pointer advance by themselves.

In the primary table, a word whose byte address has bit 1 set carries a 9-bit tile number, a 3-bit palette, a 2-bit priority and the two flip bits. The other words carry the low 8 bits of X and the 8-bit Y. Each extension byte serves four consecutive sprites. Each sprite gets one bit pair inside that byte: the even bit is the X high bit and the odd bit is the size bit. This block stores those bytes as raw data and leaves decoding to the renderer.

When priority rotation is enabled, a first-sprite index follows the pointer. A one-cycle change pulse tells downstream logic that stored content really changed. A registered read port lets a test harness inspect any byte.

Top module: `spr_attr_wport`

## Requirements
- R1: After a synchronous reset, word_ptr, byte_phase, first_spr and attr_changed are all zero.
- R2: While word_ptr bit 8 is 0, writes reach the primary table. While it is 1, writes reach the extension table.
- R3: A primary-table write with byte_phase 0 stores the byte in a staging register and sets byte_phase. It does not change memory or word_ptr.
- R4: A primary-table write with byte_phase 1 stores the staged byte at byte address 2*W and the new byte at 2*W+1, where W is word_ptr[7:0]. It clears byte_phase and increments word_ptr.
- R5: An extension write stores the byte at once at byte address 512 + 2*word_ptr[3:0] + byte_phase, so word_ptr bits 7..4 are ignored. byte_phase then toggles, and word_ptr increments only when byte_phase goes from 1 to 0.
- R6: word_ptr increments modulo 512, so 0x1FF is followed by 0x000.
- R7: When rot_en is 1 at an increment, first_spr becomes bits 7..1 of the incremented pointer. At any other time first_spr holds its value.
- R8: attr_changed is 1 for exactly the cycle after a committed write whose bytes differ from the stored ones, and 0 otherwise.
- R9: ptr_load sets word_ptr to ptr_value and clears byte_phase. A write strobe in the same cycle is ignored.
- R10: rd_data shows, one cycle after rd_addr is presented, the byte at that address as it was before any write on the same edge. Addresses 0..511 read the primary table. An address with bit 9 set reads extension byte rd_addr[4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Write byte |
| ptr_load | input | 1 | Load word pointer |
| ptr_value | input | 9 | New word pointer |
| rot_en | input | 1 | Priority rotation enable |
| rd_addr | input | 10 | Harness read byte address |
| rd_data | output | 8 | Registered read byte |
| word_ptr | output | 9 | Current word pointer |
| byte_phase | output | 1 | Byte phase bit |
| first_spr | output | 7 | First-sprite index |
| attr_changed | output | 1 | Content-change pulse |

## Verification
The bench stresses the points where an extension access and a primary access share the phase bit and the pointer:
- It runs through the primary-to-extension crossing at 0x0FF/0x100. A design that advanced the pointer on every byte would fill the wrong words there.
- It writes the extension alias at 0x1FF and wraps the pointer to 0x000. A design that did not mask bits 7..4 would write outside the 32 bytes.
- It strobes a write in the same cycle as a pointer load, and it abandons a pair half way. Here a wrong design would leave a stale phase, so every later word would be split across two addresses.
- It rewrites identical data, which a wrong design would report as changed.

// File: rtl/spr_attr_pkg.sv
package spr_attr_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic [1:0] {TGT_IDLE = 2'd0, TGT_MAIN = 2'd1, TGT_EXT = 2'd2} tgt_e;
endpackage

// File: rtl/spr_attr_ctrl.sv
module spr_attr_ctrl
  import spr_attr_pkg::*;
#(
  parameter int AW   = 9,
  parameter int EIW  = 5,
  localparam int MIW = AW - 1,
  localparam int FSW = AW - 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  byte_t          wr_data,
  input  logic           ptr_load,
  input  logic [AW-1:0]  ptr_value,
  input  logic           rot_en,
  output logic           main_we,
  output logic [MIW-1:0] main_idx,
  output logic [15:0]    main_wdata,
  output logic           ext_we,
  output logic [EIW-1:0] ext_idx,
  output byte_t          ext_wdata,
  output logic [AW-1:0]  word_ptr,
  output logic           byte_phase,
  output logic [FSW-1:0] first_spr
);
  byte_t         stage_q;
  logic          act;
  logic          inc;
  tgt_e          tgt;
  logic [AW-1:0] ptr_next;

  assign act = wr_en & ~ptr_load;

  always_comb begin
    if (!act)                tgt = TGT_IDLE;
    else if (word_ptr[AW-1]) tgt = TGT_EXT;
    else                     tgt = TGT_MAIN;
  end

  // a pair completes, or the extension phase wraps, only on phase 1
  assign inc        = act & byte_phase;
  assign ptr_next   = word_ptr + 1'b1;
  assign main_we    = (tgt == TGT_MAIN) & byte_phase;
  assign main_idx   = word_ptr[MIW-1:0];
  assign main_wdata = {wr_data, stage_q};
  assign ext_we     = (tgt == TGT_EXT);
  assign ext_idx    = {word_ptr[EIW-2:0], byte_phase};
  assign ext_wdata  = wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_ptr   <= '0;
      byte_phase <= 1'b0;
      first_spr  <= '0;
      stage_q    <= '0;
    end else if (ptr_load) begin
      word_ptr   <= ptr_value;
      byte_phase <= 1'b0;
    end else if (act) begin
      byte_phase <= ~byte_phase;
      if (tgt == TGT_MAIN && !byte_phase) stage_q <= wr_data;
      if (inc) begin
        word_ptr <= ptr_next;
        if (rot_en) first_spr <= ptr_next[FSW:1];
      end
    end
  end

  p_load_clears_r9: assert property (@(posedge clk) disable iff (rst)
    ptr_load |=> (!byte_phase && word_ptr == $past(ptr_value)));
  p_first_byte_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ptr_load && !word_ptr[AW-1] && !byte_phase) |=> (byte_phase && $stable(word_ptr)));
  p_pair_advances_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ptr_load && !word_ptr[AW-1] && byte_phase)
      |=> (!byte_phase && word_ptr == AW'($past(word_ptr) + 1'b1)));
  p_ext_toggles_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ptr_load && word_ptr[AW-1]) |=> (byte_phase != $past(byte_phase)));
  p_rot_off_holds_r7: assert property (@(posedge clk) disable iff (rst)
    !rot_en |=> $stable(first_spr));
endmodule

// File: rtl/spr_attr_mem.sv
module spr_attr_mem
  import spr_attr_pkg::*;
#(
  parameter int MIW  = 8,
  parameter int EIW  = 5,
  localparam int MAIN_WORDS = 1 << MIW,
  localparam int EXT_BYTES  = 1 << EIW,
  localparam int RAW        = MIW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           main_we,
  input  logic [MIW-1:0] main_idx,
  input  logic [15:0]    main_wdata,
  input  logic           ext_we,
  input  logic [EIW-1:0] ext_idx,
  input  byte_t          ext_wdata,
  input  logic [RAW-1:0] rd_addr,
  output byte_t          rd_data,
  output logic           attr_changed
);
  byte_t main_lo [MAIN_WORDS];
  byte_t main_hi [MAIN_WORDS];
  byte_t ext_mem [EXT_BYTES];
  logic  differs;

  always_comb begin
    differs = 1'b0;
    if (main_we)
      differs = (main_lo[main_idx] != main_wdata[7:0]) || (main_hi[main_idx] != main_wdata[15:8]);
    else if (ext_we)
      differs = (ext_mem[ext_idx] != ext_wdata);
  end

  always_ff @(posedge clk) begin
    if (main_we) begin
      main_lo[main_idx] <= main_wdata[7:0];
      main_hi[main_idx] <= main_wdata[15:8];
    end
    if (ext_we) ext_mem[ext_idx] <= ext_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data      <= '0;
      attr_changed <= 1'b0;
    end else begin
      attr_changed <= differs;
      if (rd_addr[RAW-1])  rd_data <= ext_mem[rd_addr[EIW-1:0]];
      else if (rd_addr[0]) rd_data <= main_hi[rd_addr[MIW:1]];
      else                 rd_data <= main_lo[rd_addr[MIW:1]];
    end
  end

  p_one_table_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({main_we, ext_we}));
  p_quiet_no_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    !(main_we || ext_we) |=> !attr_changed);
endmodule

// File: rtl/spr_attr_wport.sv
module spr_attr_wport
  import spr_attr_pkg::*;
#(
  parameter int AW = 9,
  parameter int EXT_BYTES = 32,
  localparam int MIW = AW - 1,
  localparam int EIW = $clog2(EXT_BYTES),
  localparam int RAW = AW + 1,
  localparam int FSW = AW - 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [7:0]     wr_data,
  input  logic           ptr_load,
  input  logic [AW-1:0]  ptr_value,
  input  logic           rot_en,
  input  logic [RAW-1:0] rd_addr,
  output logic [7:0]     rd_data,
  output logic [AW-1:0]  word_ptr,
  output logic           byte_phase,
  output logic [FSW-1:0] first_spr,
  output logic           attr_changed
);
  logic           main_we;
  logic [MIW-1:0] main_idx;
  logic [15:0]    main_wdata;
  logic           ext_we;
  logic [EIW-1:0] ext_idx;
  byte_t          ext_wdata;

  spr_attr_ctrl #(.AW(AW), .EIW(EIW)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ptr_load(ptr_load), .ptr_value(ptr_value), .rot_en(rot_en),
    .main_we(main_we), .main_idx(main_idx), .main_wdata(main_wdata),
    .ext_we(ext_we), .ext_idx(ext_idx), .ext_wdata(ext_wdata),
    .word_ptr(word_ptr), .byte_phase(byte_phase), .first_spr(first_spr)
  );

  spr_attr_mem #(.MIW(MIW), .EIW(EIW)) u_mem (
    .clk(clk), .rst(rst),
    .main_we(main_we), .main_idx(main_idx), .main_wdata(main_wdata),
    .ext_we(ext_we), .ext_idx(ext_idx), .ext_wdata(ext_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .attr_changed(attr_changed)
  );

  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ptr_load && byte_phase && word_ptr == '1) |=> (word_ptr == '0));
endmodule

// File: tb/sim_spr_attr_wport.sv
module sim_spr_attr_wport;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic ptr_load = 1'b0;
  logic [8:0] ptr_value = '0;
  logic rot_en = 1'b0;
  logic [9:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [8:0] word_ptr;
  logic byte_phase;
  logic [6:0] first_spr;
  logic attr_changed;

  always #2.5 clk = ~clk;

  spr_attr_wport u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ptr_load(ptr_load), .ptr_value(ptr_value), .rot_en(rot_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .word_ptr(word_ptr),
    .byte_phase(byte_phase), .first_spr(first_spr), .attr_changed(attr_changed)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference state
  int  m_mem [544];
  bit  m_val [544];
  int  m_ptr = 0;
  int  m_ph = 0;
  int  m_stage = 0;
  int  m_first = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rd_map(logic [9:0] a);
    return a[9] ? 512 + int'(a[4:0]) : int'(a[8:0]);
  endfunction

  task automatic advance();
    m_ptr = (m_ptr + 1) & 511;
    if (rot_en) m_first = (m_ptr & 254) >> 1;
  endtask

  // one clock: inputs already driven; predict, clock, compare
  task automatic tick(string tag);
    int  ri, e, b;
    int  exp_rd;
    bit  rd_known, chg_known, chg;
    ri = rd_map(rd_addr);
    rd_known = m_val[ri];
    exp_rd = m_mem[ri];
    chg_known = 1; chg = 0;
    if (ptr_load) begin
      m_ptr = int'(ptr_value); m_ph = 0;
    end else if (wr_en) begin
      if (m_ptr >= 256) begin
        e = 512 + (m_ptr & 15) * 2 + m_ph;
        chg_known = m_val[e];
        chg = m_mem[e] != int'(wr_data);
        m_mem[e] = int'(wr_data); m_val[e] = 1;
        m_ph ^= 1;
        if (m_ph == 0) advance();
      end else if (m_ph == 0) begin
        m_stage = int'(wr_data); m_ph = 1;
      end else begin
        b = (m_ptr & 255) * 2;
        chg_known = m_val[b] && m_val[b+1];
        chg = (m_mem[b] != m_stage) || (m_mem[b+1] != int'(wr_data));
        m_mem[b] = m_stage; m_mem[b+1] = int'(wr_data);
        m_val[b] = 1; m_val[b+1] = 1;
        m_ph = 0;
        advance();
      end
    end
    @(posedge clk); #1;
    chk({tag, "/R4 ptr"}, int'(word_ptr), m_ptr);
    chk({tag, "/R3 phase"}, int'(byte_phase), m_ph);
    chk({tag, "/R7 first"}, int'(first_spr), m_first);
    if (chg_known) chk({tag, "/R8 changed"}, int'(attr_changed), int'(chg));
    if (rd_known) chk({tag, "/R10 read"}, int'(rd_data), exp_rd);
  endtask

  task automatic put(logic [7:0] d, string tag);
    wr_en = 1; wr_data = d; tick(tag); wr_en = 0;
  endtask

  task automatic load(logic [8:0] a, string tag);
    ptr_load = 1; ptr_value = a; tick(tag); ptr_load = 0;
  endtask

  task automatic peek(int a, int exp, string tag);
    rd_addr = 10'(a); tick(tag);
    chk({tag, " direct"}, int'(rd_data), exp);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 544; i++) begin m_mem[i] = 0; m_val[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    chk("R1 ptr", int'(word_ptr), 0);
    chk("R1 phase", int'(byte_phase), 0);
    chk("R1 first", int'(first_spr), 0);
    chk("R1 changed", int'(attr_changed), 0);

    // fill primary then run into extension (R2 crossing at 0x100)
    load(9'h000, "fill");
    for (int i = 0; i < 544; i++) put(8'(i * 7 + 3), "R2 fill");
    chk("R2 ptr after fill", int'(word_ptr), 9'h110);
    for (int i = 0; i < 544; i++) begin
      rd_addr = (i < 512) ? 10'(i) : 10'(512 + i - 512);
      tick("R10 sweep");
    end
    peek(512 + 5, m_mem[517], "R10 ext");

    // R3 half pair leaves memory alone, R9 load abandons it
    load(9'h010, "R3");
    put(8'hEE, "R3 first byte");
    peek(32, m_mem[32], "R3 untouched");
    ptr_load = 1; ptr_value = 9'h020; wr_en = 1; wr_data = 8'h99;
    tick("R9 load beats write");
    ptr_load = 0; wr_en = 0;
    chk("R9 phase cleared", int'(byte_phase), 0);
    put(8'h12, "R4 lo"); put(8'h34, "R4 hi");
    peek(64, 8'h12, "R4 even byte");
    peek(65, 8'h34, "R4 odd byte");

    // R8 identical rewrite then different
    load(9'h020, "R8");
    put(8'h12, "R8 same lo"); put(8'h34, "R8 same hi");
    chk("R8 no pulse", int'(attr_changed), 0);
    load(9'h020, "R8b");
    put(8'h12, "R8 lo"); put(8'h35, "R8 diff hi");
    chk("R8 pulse", int'(attr_changed), 1);
    tick("R8 idle");
    chk("R8 one cycle", int'(attr_changed), 0);

    // R5 alias + R6 wrap + R7 rotation
    rot_en = 1;
    load(9'h1F3, "R5");
    put(8'hA1, "R5 ext0"); put(8'hB2, "R5 ext1");
    peek(512 + 6, 8'hA1, "R5 alias even");
    peek(512 + 7, 8'hB2, "R5 alias odd");
    load(9'h1FF, "R6");
    put(8'hC3, "R6 a"); put(8'hD4, "R6 b");
    chk("R6 wrapped", int'(word_ptr), 0);
    chk("R7 first after wrap", int'(first_spr), 0);
    load(9'h0FE, "R7");
    put(8'h01, "R7 a"); put(8'h02, "R7 b");
    chk("R7 first", int'(first_spr), 7'h7F);
    rot_en = 0;
    put(8'h03, "R7 off a"); put(8'h04, "R7 off b");
    chk("R7 hold", int'(first_spr), 7'h7F);

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      rot_en = ($urandom_range(0, 3) == 0);
      rd_addr = 10'($urandom_range(0, 1023));
      if (r < 6) begin
        ptr_load = 1; ptr_value = 9'($urandom_range(0, 511));
      end
      if (r >= 3 && r < 70) begin
        wr_en = 1; wr_data = 8'($urandom_range(0, 3));
      end
      tick("mix");
      ptr_load = 0; wr_en = 0;
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule